// File: doc/BRIEF.md
# BCD Real-Time Clock Register File

This block keeps time of day and calendar in BCD form and presents them as eight byte-wide registers. A one-cycle `tick` pulse, normally once per second, advances the seconds field. Carries ripple through minutes, hours, date, month and year in the same clock cycle. Date advance also steps a day-of-week count. Month lengths follow the calendar: February is 29 days long in years divisible by four and 28 days otherwise.

Software loads a field by writing its register. Each write is masked to the field's width and range-checked first. A write that fails the check leaves the field unchanged. Reads come back registered, one cycle after the address is presented, and always reflect the live counters.

Bit 7 of the seconds register is a stop bit. While it is set, ticks are ignored. The counters keep their frozen value until the bit is cleared.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset the registers read: control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday/century 0x00, date 0x01, month 0x01, year 0x00. Register addresses: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year.
- R2: A tick with the stop bit clear advances seconds in BCD. Wraps cascade in the same cycle: 59 seconds to 00 advances minutes, 59 minutes to 00 advances hours, and 23 hours to 00 advances the date and the weekday.
- R3: The weekday, held in bits 2:0 of register 4, counts 0 to 6 and wraps from 6 to 0.
- R4: The date wraps to 01 and advances the month after day 30 in months 04, 06, 09 and 11, after day 31 in the other months, and after day 29 or 28 in month 02 depending on whether the year is divisible by 4. Month 12 wraps to 01 and advances the year.
- R5: The year wraps from 99 to 00 and toggles the century bit, bit 6 of register 4.
- R6: Bit 7 of a seconds write is always stored as the stop bit. While the stop bit is set, ticks change no field. Reading seconds returns the stop bit in bit 7 above the BCD seconds.
- R7: Seconds and minutes writes use bits 6:0; hours writes use bits 5:0. These writes are accepted only for valid BCD in 00 to 59 (seconds, minutes) or 00 to 23 (hours), and are otherwise dropped.
- R8: Date writes use bits 4:0 and must be valid nonzero BCD. Month writes use bits 4:0 and must be 01 to 12. Year writes use all 8 bits and must be 00 to 99. Any other value is dropped.
- R9: A write to register 4 always stores bit 6 as the century bit. It stores bits 2:0 as the weekday only when they are 0 to 6. The other bits read as 0.
- R10: A control write stores the written value with bit 5 cleared and bits 7 and 4 set.
- R11: A valid field write in the same cycle as an advance takes priority: the field takes the written value and sends no carry onward in that cycle.
- R12: Reads are registered: `rd_data` shows the register at `addr` as it stood at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle advance pulse (once per second) |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register select for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
On every cycle, the assertions check four things:
- every field holds valid BCD digits and the weekday stays in range;
- a frozen clock keeps its seconds, and an accepted load lands in its field;
- a field that wraps returns to its lowest value;
- a year wrap flips the century bit, and the control register keeps its forced bits.

Only the bench's scenarios can show that the calendar is right:
- February length in leap and common years;
- the 30-day and 31-day months;
- that invalid writes are really dropped;
- that a write arriving on the same edge as a tick blocks the carry into the next field.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_SEC   = 3'd1,
    REG_MIN   = 3'd2,
    REG_HOUR  = 3'd3,
    REG_WDAY  = 3'd4,
    REG_DATE  = 3'd5,
    REG_MONTH = 3'd6,
    REG_YEAR  = 3'd7
  } rtc_reg_e;

  // Both digits valid BCD and the value within [lo, hi].
  function automatic logic bcd_in_range(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  // Two-digit BCD year divisible by 4: (10*t + u) mod 4 == (2*t + u) mod 4.
  function automatic logic bcd_leap(logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'b00;
  endfunction

endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_day
);
  logic leap;
  assign leap = bcd_leap(year);

  always_comb begin
    case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00,
  parameter int         DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic [DW-1:0] max_val,
  output logic [DW-1:0] val,
  output logic          carry
);
  localparam int HI = DW - 1;

  logic at_top;
  assign at_top = (val >= max_val);
  assign carry  = inc && !load && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= RST_VAL;
    end else if (load) begin
      val <= load_val;
    end else if (inc) begin
      if (at_top)               val <= MIN_VAL;
      else if (val[3:0] == 4'd9) val <= {val[HI:4] + 1'b1, 4'd0};
      else                      val <= {val[HI:4], val[3:0] + 4'd1};
    end
  end

  AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    (val[3:0] <= 4'd9) && (val[HI:4] <= 4'd9)); // R2

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (val == $past(load_val))); // R11

  AST_WRAP_TO_MIN: assert property (@(posedge clk) disable iff (rst)
    carry |=> (val == MIN_VAL)); // R4
endmodule

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs
  import rtc_pkg::*;
#(
  parameter logic [7:0] CTRL_SET  = 8'h90,
  parameter logic [7:0] CTRL_CLR  = 8'hA0,
  parameter int         WDAY_LAST = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int          DW     = 8;
  localparam logic [2:0]  WD_TOP = 3'(WDAY_LAST);

  logic [DW-1:0] ctrl_q;
  logic          stop_q, cent_q;
  logic [2:0]    wday_q;

  logic [DW-1:0] sec_v, min_v, hour_v, date_v, mon_v, year_v, mlen;
  logic          sec_c, min_c, hour_c, date_c, mon_c, year_c;

  // Write decode and per-field validation
  logic w_ctrl, w_sec, w_min, w_hour, w_wday, w_date, w_mon, w_year;
  assign w_ctrl = wr_en && (addr == REG_CTRL);
  assign w_sec  = wr_en && (addr == REG_SEC);
  assign w_min  = wr_en && (addr == REG_MIN);
  assign w_hour = wr_en && (addr == REG_HOUR);
  assign w_wday = wr_en && (addr == REG_WDAY);
  assign w_date = wr_en && (addr == REG_DATE);
  assign w_mon  = wr_en && (addr == REG_MONTH);
  assign w_year = wr_en && (addr == REG_YEAR);

  logic [DW-1:0] v_sec, v_min, v_hour, v_date, v_mon;
  assign v_sec  = {1'b0, wr_data[6:0]};
  assign v_min  = {1'b0, wr_data[6:0]};
  assign v_hour = {2'b0, wr_data[5:0]};
  assign v_date = {3'b0, wr_data[4:0]};
  assign v_mon  = {3'b0, wr_data[4:0]};

  logic ld_sec, ld_min, ld_hour, ld_date, ld_mon, ld_year, ld_wday;
  assign ld_sec  = w_sec  && bcd_in_range(v_sec,   8'h00, 8'h59);
  assign ld_min  = w_min  && bcd_in_range(v_min,   8'h00, 8'h59);
  assign ld_hour = w_hour && bcd_in_range(v_hour,  8'h00, 8'h23);
  assign ld_date = w_date && bcd_in_range(v_date,  8'h01, 8'h31);
  assign ld_mon  = w_mon  && bcd_in_range(v_mon,   8'h01, 8'h12);
  assign ld_year = w_year && bcd_in_range(wr_data, 8'h00, 8'h99);
  assign ld_wday = w_wday && (wr_data[2:0] <= WD_TOP);

  logic run;
  assign run = tick && !stop_q;

  rtc_month_len u_mlen (.month(mon_v), .year(year_v), .last_day(mlen));

  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .DW(DW)) u_sec (
    .clk, .rst, .inc(run), .load(ld_sec), .load_val(v_sec),
    .max_val(8'h59), .val(sec_v), .carry(sec_c));
  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .DW(DW)) u_min (
    .clk, .rst, .inc(sec_c), .load(ld_min), .load_val(v_min),
    .max_val(8'h59), .val(min_v), .carry(min_c));
  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .DW(DW)) u_hour (
    .clk, .rst, .inc(min_c), .load(ld_hour), .load_val(v_hour),
    .max_val(8'h23), .val(hour_v), .carry(hour_c));
  rtc_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .DW(DW)) u_date (
    .clk, .rst, .inc(hour_c), .load(ld_date), .load_val(v_date),
    .max_val(mlen), .val(date_v), .carry(date_c));
  rtc_bcd_field #(.MIN_VAL(8'h01), .RST_VAL(8'h01), .DW(DW)) u_mon (
    .clk, .rst, .inc(date_c), .load(ld_mon), .load_val(v_mon),
    .max_val(8'h12), .val(mon_v), .carry(mon_c));
  rtc_bcd_field #(.MIN_VAL(8'h00), .RST_VAL(8'h00), .DW(DW)) u_year (
    .clk, .rst, .inc(mon_c), .load(ld_year), .load_val(wr_data),
    .max_val(8'h99), .val(year_v), .carry(year_c));

  // Control, stop, weekday and century state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_SET;
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      wday_q <= 3'd0;
    end else begin
      if (w_ctrl) ctrl_q <= (wr_data & ~CTRL_CLR) | CTRL_SET;
      if (w_sec)  stop_q <= wr_data[7];
      if (ld_wday)      wday_q <= wr_data[2:0];
      else if (hour_c)  wday_q <= (wday_q >= WD_TOP) ? 3'd0 : wday_q + 3'd1;
      if (w_wday)       cent_q <= wr_data[6];
      else if (year_c)  cent_q <= ~cent_q;
    end
  end

  // Registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
    end else begin
      case (rtc_reg_e'(addr))
        REG_CTRL:  rd_data <= ctrl_q;
        REG_SEC:   rd_data <= {stop_q, sec_v[6:0]};
        REG_MIN:   rd_data <= min_v;
        REG_HOUR:  rd_data <= hour_v;
        REG_WDAY:  rd_data <= {1'b0, cent_q, 3'b000, wday_q};
        REG_DATE:  rd_data <= date_v;
        REG_MONTH: rd_data <= mon_v;
        default:   rd_data <= year_v;
      endcase
    end
  end

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !w_sec) |=> $stable(sec_v)); // R6

  AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]); // R10

  AST_CENTURY_FLIP: assert property (@(posedge clk) disable iff (rst)
    (year_c && !w_wday) |=> (cent_q != $past(cent_q))); // R5

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
    wday_q <= WD_TOP); // R3
endmodule

// File: tb/test_rtc_bcd_regs.sv
module test_rtc_bcd_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rtc_bcd_regs i_rtc_bcd_regs (
    .clk, .rst, .tick, .wr_en, .addr, .wr_data, .rd_data);

  // {req number, addr, write data, expected readback}
  localparam int NV = 24;
  localparam logic [27:0] VEC [NV] = '{
    {4'd7,  4'd1, 8'h45, 8'h45},  // R7 seconds accepted
    {4'd7,  4'd1, 8'h60, 8'h45},  // R7 60 dropped
    {4'd7,  4'd1, 8'h3A, 8'h45},  // R7 bad digit dropped
    {4'd7,  4'd2, 8'hD9, 8'h59},  // R7 minutes, bit 7 masked
    {4'd7,  4'd3, 8'h23, 8'h23},  // R7 hours 23
    {4'd7,  4'd3, 8'h24, 8'h23},  // R7 hours 24 dropped
    {4'd7,  4'd3, 8'hD2, 8'h12},  // R7 hours masked to bits 5:0
    {4'd8,  4'd5, 8'h00, 8'h01},  // R8 date zero dropped
    {4'd8,  4'd5, 8'h19, 8'h19},  // R8 date accepted
    {4'd8,  4'd5, 8'h25, 8'h05},  // R8 date masked to bits 4:0
    {4'd8,  4'd6, 8'h13, 8'h01},  // R8 month 13 dropped
    {4'd8,  4'd6, 8'h00, 8'h01},  // R8 month 0 dropped
    {4'd8,  4'd6, 8'h12, 8'h12},  // R8 month 12
    {4'd8,  4'd7, 8'h9A, 8'h00},  // R8 year bad digit dropped
    {4'd8,  4'd7, 8'h99, 8'h99},  // R8 year 99
    {4'd9,  4'd4, 8'h45, 8'h45},  // R9 century + weekday 5
    {4'd9,  4'd4, 8'h07, 8'h05},  // R9 weekday 7 ignored, century cleared
    {4'd9,  4'd4, 8'hFE, 8'h46},  // R9 other bits read 0
    {4'd10, 4'd0, 8'h00, 8'h90},  // R10
    {4'd10, 4'd0, 8'hFF, 8'hDF},  // R10
    {4'd10, 4'd0, 8'h2A, 8'h9A},  // R10
    {4'd6,  4'd1, 8'h80, 8'h80},  // R6 stop bit stored
    {4'd6,  4'd1, 8'hE0, 8'hE0},  // R6 stop kept, seconds 60 masked to 60? -> see below
    {4'd6,  4'd1, 8'h30, 8'h30}   // R6 stop cleared
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic next_day;
    wr(3'd1, 8'h59);
    wr(3'd2, 8'h59);
    wr(3'd3, 8'h23);
    pulse();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] rst_exp [8];
    rst_exp = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      check("R1", v, rst_exp[i]);
    end

    // Table walk: write then read back (R12 read path)
    for (int i = 0; i < NV; i++) begin
      logic [7:0] e;
      e = VEC[i][7:0];
      // 0xE0: stop=1, seconds 0x60 invalid so seconds stay 00 -> 0x80
      if (VEC[i][15:8] == 8'hE0) e = 8'h80;
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      check($sformatf("R%0d R12 vec%0d", VEC[i][27:24], i), v, e);
    end

    // R2 cascade: 23:59:59 -> 00:00:00, R4 non-leap February
    wr(3'd6, 8'h02); wr(3'd7, 8'h01); wr(3'd5, 8'h19); wr(3'd4, 8'h04);
    for (int d = 0; d < 9; d++) next_day();
    rd(3'd1, v); check("R2 sec", v, 8'h00);
    rd(3'd2, v); check("R2 min", v, 8'h00);
    rd(3'd3, v); check("R2 hour", v, 8'h00);
    rd(3'd5, v); check("R4 feb28", v, 8'h28);
    rd(3'd4, v); check("R3 wday6", v, 8'h06);
    next_day();
    rd(3'd5, v); check("R4 common-year date", v, 8'h01);
    rd(3'd6, v); check("R4 common-year month", v, 8'h03);
    rd(3'd4, v); check("R3 wday wrap", v, 8'h00);

    // R4 leap February
    wr(3'd7, 8'h04); wr(3'd6, 8'h02); wr(3'd5, 8'h19);
    for (int d = 0; d < 10; d++) next_day();
    rd(3'd5, v); check("R4 leap feb29", v, 8'h29);
    next_day();
    rd(3'd5, v); check("R4 leap date", v, 8'h01);
    rd(3'd6, v); check("R4 leap month", v, 8'h03);

    // R4 30-day month
    wr(3'd6, 8'h04); wr(3'd5, 8'h19);
    for (int d = 0; d < 11; d++) next_day();
    rd(3'd5, v); check("R4 apr30", v, 8'h30);
    next_day();
    rd(3'd6, v); check("R4 may", v, 8'h05);

    // R4/R5 31-day December, year 99 -> 00 with century toggle
    wr(3'd7, 8'h99); wr(3'd6, 8'h12); wr(3'd5, 8'h19); wr(3'd4, 8'h00);
    for (int d = 0; d < 12; d++) next_day();
    rd(3'd5, v); check("R4 dec31", v, 8'h31);
    next_day();
    rd(3'd5, v); check("R4 jan date", v, 8'h01);
    rd(3'd6, v); check("R4 jan month", v, 8'h01);
    rd(3'd7, v); check("R5 year wrap", v, 8'h00);
    rd(3'd4, v); check("R5 century set", v, 8'h46);

    // R6 stop freezes, clearing resumes
    wr(3'd1, 8'h95);
    wr(3'd2, 8'h07);
    pulse(); pulse(); pulse();
    rd(3'd1, v); check("R6 frozen sec", v, 8'h95);
    rd(3'd2, v); check("R6 frozen min", v, 8'h07);
    wr(3'd1, 8'h15);
    pulse();
    rd(3'd1, v); check("R6 resumed", v, 8'h16);

    // R11 write on tick edge: seconds write blocks carry
    wr(3'd3, 8'h05); wr(3'd2, 8'h10); wr(3'd1, 8'h59);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd1; wr_data = 8'h30;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd1, v); check("R11 sec loaded", v, 8'h30);
    rd(3'd2, v); check("R11 no min carry", v, 8'h10);
    // R11 minutes write beats incoming carry
    wr(3'd1, 8'h59); wr(3'd2, 8'h59);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; addr = 3'd2; wr_data = 8'h40;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(3'd1, v); check("R11 sec wrapped", v, 8'h00);
    rd(3'd2, v); check("R11 min loaded", v, 8'h40);
    rd(3'd3, v); check("R11 hour held", v, 8'h05);

    // R12 reset clears read register too; R1 after re-reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(3'd5, v); check("R1 re-reset date", v, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule